// File: doc/BRIEF.md
# True Random Number Generator Control Block

This block is the register-facing sequencer for an entropy source. Software turns on the analog front end through an activation register, then waits for a ready flag. The flag rises after a fixed warm-up time, which is modelled as a cycle count. Once ready is up, software may turn on byte generation or seed generation. Entropy arrives on a 1-bit input qualified by a strobe. The block packs those bits into bytes that are read once through a data register, or into 32-bit seeds for a downstream pseudo-random generator.

The bus port is a simple single-cycle one. Read data is combinational from the address. Writes, and the clearing that a data read causes, take effect on the clock edge of the access. A level interrupt reports that a byte is waiting. While seed generation runs, the data register reads as zero and keeps its contents. The seed request clears itself when the seed is complete.

Top module: `rng_ctrl_regs`

## Requirements
- R1: After reset, reads of the control word (offset 0x0), the data register (offset 0x4) and the activation register (offset 0xC) all return 0. The outputs irq and seed_word are also 0.
- R2: Ready (control bit 7) rises on the Nth clock edge after the edge that writes 1 to activation bit 7 of offset 0xC, where N = CLK_MHZ*WARMUP_US. Ready falls on the first edge after activation reads back 0.
- R3: A write of 1 to enable (control bit 0) or to seed request (control bit 8) is ignored unless activation and ready are both 1.
- R4: While enable is 1, ready is 1 and seed request is 0, each group of 8 entropy strobes forms a byte. The first bit of the group lands in bit 7 of the byte. On the eighth strobe the byte is stored and data-valid (control bit 1) rises.
- R5: A read of offset 0x4 while data-valid is 1 returns the byte in bits 7:0. That read clears data-valid, so a second read returns 0.
- R6: A read of offset 0x4 while data-valid is 0 returns 0x00000000.
- R7: A byte completed while data-valid is already 1 is discarded. The held byte is kept, and the next group of 8 strobes starts afresh.
- R8: irq is 1 exactly when data-valid and interrupt enable (control bit 6) are both 1.
- R9: The clock range field (control bits 5:2) takes a written value only while enable is 0. A write of the reserved code 15 is ignored.
- R10: With seed request set, 32 strobes form a seed, first bit in bit 31, presented on seed_word. Seed-ready (control bit 9) then rises and seed request drops to 0 in the same edge.
- R11: While seed request is 1, seed-ready reads 0. Reads of offset 0x4 return 0 and leave data-valid and the held byte untouched.
- R12: Entropy strobes are ignored while the generator is neither enabled nor in seed mode, or while ready is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| ent_bit | input | 1 | Entropy bit |
| ent_stb | input | 1 | Entropy bit is valid this cycle |
| irq | output | 1 | Level interrupt: byte waiting |
| seed_word | output | 32 | Last completed seed |

## Verification
The bench targets the exact edge on which ready rises and falls. A timer that is off by one, or that keeps counting after activation drops, shows up as a wrong ready bit on a neighbouring cycle. It writes enable, seed request and the clock range at times when those writes must be refused. A design without the guards would show the bit or the code in the read-back. It sends a second byte before the first is read, and it reads the data register during seed mode. A block that overwrites the held byte, or that empties it while the register is hidden, then returns the wrong value on the final read. Patterns chosen so that either bit order gives a different value catch a packer that fills the byte or the seed from the wrong end.

// File: rtl/rng_ctrl_pkg.sv
package rng_ctrl_pkg;
  localparam int REG_W  = 32;
  localparam int BYTE_W = 8;
  localparam int SEED_W = 32;

  localparam int OFS_CTL = 'h0;
  localparam int OFS_DAT = 'h4;
  localparam int OFS_ACT = 'hC;

  localparam int B_EN     = 0;
  localparam int B_DV     = 1;
  localparam int B_CLK_LO = 2;
  localparam int B_IE     = 6;
  localparam int B_RDY    = 7;
  localparam int B_SG     = 8;
  localparam int B_SR     = 9;
  localparam int B_ACT    = 7;

  localparam logic [3:0] CLKR_RESERVED = 4'hF;

  typedef logic [SEED_W-1:0] seed_t;

  // new entropy bit enters at the bottom; the oldest bit ends at the top
  function automatic seed_t shift_in(seed_t v, logic b);
    return {v[SEED_W-2:0], b};
  endfunction

  function automatic logic [REG_W-1:0] pack_ctl(logic en, logic dv, logic [3:0] clkr,
                                                 logic ie, logic rdy, logic sg, logic sr);
    logic [REG_W-1:0] w;
    w = '0;
    w[B_EN] = en;
    w[B_DV] = dv;
    w[B_CLK_LO +: 4] = clkr;
    w[B_IE] = ie;
    w[B_RDY] = rdy;
    w[B_SG] = sg;
    w[B_SR] = sr;
    return w;
  endfunction
endpackage

// File: rtl/rng_warmup.sv
module rng_warmup #(
  parameter int WARM_CNT = 10000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act,
  output logic ready
);
  localparam int CW = $clog2(WARM_CNT + 1);

  logic [CW-1:0] cnt;
  logic          last_tick;

  assign last_tick = (cnt == CW'(WARM_CNT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      ready <= 1'b0;
    end else if (!act) begin
      cnt   <= '0;
      ready <= 1'b0;
    end else if (!ready) begin
      if (last_tick) ready <= 1'b1;
      else           cnt   <= cnt + 1'b1;
    end
  end

  // R2: ready cannot survive an inactive front end
  p_ready_drops_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !act |=> !ready);
  // R2: once up, ready holds while activation stays on
  p_ready_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && act) |=> ready);
endmodule

// File: rtl/rng_bit_gather.sv
module rng_bit_gather
  import rng_ctrl_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clear,
  input  logic  long_mode,
  input  logic  stb,
  input  logic  bit_in,
  output seed_t word_next,
  output logic  done
);
  localparam int CW = $clog2(SEED_W);

  seed_t         sr;
  logic [CW-1:0] cnt;
  logic [CW-1:0] last;
  logic          mode_q;
  logic          restart;

  assign restart   = clear || (long_mode != mode_q);
  assign last      = long_mode ? CW'(SEED_W - 1) : CW'(BYTE_W - 1);
  assign word_next = shift_in(sr, bit_in);
  assign done      = stb && !restart && (cnt == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr     <= '0;
      cnt    <= '0;
      mode_q <= 1'b0;
    end else begin
      mode_q <= long_mode;
      if (restart) begin
        sr  <= '0;
        cnt <= '0;
      end else if (stb) begin
        sr  <= word_next;
        cnt <= done ? '0 : cnt + 1'b1;
      end
    end
  end

  // R4: in byte mode the bit count never passes the byte length
  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!long_mode && (long_mode == mode_q)) |-> (cnt < CW'(BYTE_W)));
endmodule

// File: rtl/rng_ctrl_regs.sv
module rng_ctrl_regs
  import rng_ctrl_pkg::*;
#(
  parameter int CLK_MHZ   = 100,
  parameter int WARMUP_US = 100,
  parameter int ADDR_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              ent_bit,
  input  logic              ent_stb,
  output logic              irq,
  output logic [SEED_W-1:0] seed_word
);
  localparam int WARM_CNT = CLK_MHZ * WARMUP_US;

  logic              act, en, dv, ie, sg, sr;
  logic [3:0]        clkr;
  logic [BYTE_W-1:0] data_q;
  seed_t             seed_q;

  logic  warm_ready, analog_ok, gather_on, acc_done;
  logic  hit_ctl, hit_dat, hit_act;
  logic  wr_ctl, wr_act, rd_dat;
  logic  byte_take, seed_take, dat_consume, sg_set;
  logic  [3:0] clkr_wr;
  seed_t word_next;

  assign hit_ctl = bus_addr == ADDR_W'(OFS_CTL);
  assign hit_dat = bus_addr == ADDR_W'(OFS_DAT);
  assign hit_act = bus_addr == ADDR_W'(OFS_ACT);
  assign wr_ctl  = bus_sel && bus_wr && hit_ctl;
  assign wr_act  = bus_sel && bus_wr && hit_act;
  assign rd_dat  = bus_sel && !bus_wr && hit_dat;

  assign analog_ok   = act && warm_ready;
  assign gather_on   = warm_ready && (en || sg);
  assign byte_take   = acc_done && !sg && !dv;
  assign seed_take   = acc_done && sg;
  assign dat_consume = rd_dat && dv && !sg;
  assign sg_set      = wr_ctl && bus_wdata[B_SG] && analog_ok && !sg;
  assign clkr_wr     = bus_wdata[B_CLK_LO +: 4];

  rng_warmup #(.WARM_CNT(WARM_CNT)) warm_i (
    .clk   (clk),
    .rst_n (rst_n),
    .act   (act),
    .ready (warm_ready)
  );

  rng_bit_gather gather_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (!gather_on),
    .long_mode (sg),
    .stb       (ent_stb && gather_on),
    .bit_in    (ent_bit),
    .word_next (word_next),
    .done      (acc_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act    <= 1'b0;
      en     <= 1'b0;
      ie     <= 1'b0;
      clkr   <= '0;
      sg     <= 1'b0;
      sr     <= 1'b0;
      dv     <= 1'b0;
      data_q <= '0;
      seed_q <= '0;
    end else begin
      if (wr_act) act <= bus_wdata[B_ACT];
      if (wr_ctl) begin
        en <= bus_wdata[B_EN] ? (en || analog_ok) : 1'b0;
        ie <= bus_wdata[B_IE];
        if (!en && clkr_wr != CLKR_RESERVED) clkr <= clkr_wr;
      end
      if (seed_take) begin
        sg     <= 1'b0;
        sr     <= 1'b1;
        seed_q <= word_next;
      end else if (wr_ctl) begin
        sg <= bus_wdata[B_SG] ? (sg || analog_ok) : 1'b0;
        if (sg_set) sr <= 1'b0;
      end
      if (byte_take) begin
        dv     <= 1'b1;
        data_q <= word_next[BYTE_W-1:0];
      end else if (dat_consume) begin
        dv     <= 1'b0;
        data_q <= '0;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      if (hit_ctl)      bus_rdata = pack_ctl(en, dv, clkr, ie, warm_ready, sg, sr);
      else if (hit_dat) bus_rdata = (dv && !sg) ? REG_W'(data_q) : '0;
      else if (hit_act) bus_rdata[B_ACT] = act;
    end
  end

  assign irq       = dv && ie;
  assign seed_word = seed_q;

  wire unused_wdata = ^{bus_wdata[REG_W-1:B_SR], bus_wdata[B_DV]};

  // R3: enable and seed request only rise on an activated, ready front end
  p_en_guard_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en) |-> $past(act && warm_ready));
  p_sg_guard_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sg) |-> $past(act && warm_ready));
  // R9: clock range is frozen while enabled
  p_clkr_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(en) |-> $stable(clkr));
  // R7: data-valid only rises from a finished byte
  p_dv_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dv) |-> $past(acc_done && !sg));
  // R5: an accepted data read empties the register
  p_read_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dat_consume |=> !dv);
  // R10: seed completion drops the request
  p_seed_clears_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sr) |-> !sg);
  // R11: seed-ready low and held byte kept while seeding
  p_seed_hides_r11: assert property (@(posedge clk) disable iff (!rst_n)
    sg |-> !sr);
  p_seed_keeps_dv_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (sg && dv) |=> dv);
endmodule

// File: tb/rng_ctrl_regs_tb.sv
module rng_ctrl_regs_tb_top;
  localparam int TB_MHZ  = 1;
  localparam int TB_US   = 20;
  localparam int WARM    = 20;   // 1 MHz * 20 us
  localparam int NVEC    = 5;
  // bit 8 = interrupt enable, bits 7:0 = byte pattern
  localparam logic [8:0] VECS [0:NVEC-1] = '{9'h0A5, 9'h13C, 9'h0FF, 9'h100, 9'h181};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        ent_bit = 1'b0, ent_stb = 1'b0;
  logic        irq;
  logic [31:0] seed_word;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] rd;

  always #5 clk = ~clk;

  rng_ctrl_regs #(.CLK_MHZ(TB_MHZ), .WARMUP_US(TB_US), .ADDR_W(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ent_bit(ent_bit), .ent_stb(ent_stb), .irq(irq), .seed_word(seed_word)
  );

  function automatic logic [31:0] ctl(logic en, logic dv, logic [3:0] ck, logic ie,
                                       logic rdy, logic sg, logic sr);
    return (32'(sr) << 9) | (32'(sg) << 8) | (32'(rdy) << 7) | (32'(ie) << 6)
         | (32'(ck) << 2) | (32'(dv) << 1) | 32'(en);
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rdreg(logic [3:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic send_bit(logic b);
    ent_stb = 1'b1; ent_bit = b;
    @(negedge clk);
    ent_stb = 1'b0;
  endtask

  task automatic send_byte(logic [7:0] b);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
  endtask

  task automatic send_word(logic [31:0] w);
    for (int i = 31; i >= 0; i--) send_bit(w[i]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rdreg(4'h0, rd); check("R1 ctl", rd, 32'h0);
    rdreg(4'h4, rd); check("R1 data", rd, 32'h0);
    rdreg(4'hC, rd); check("R1 act", rd, 32'h0);
    check("R1 irq", 32'(irq), 32'h0);
    check("R1 seed", seed_word, 32'h0);

    // R3 enable / seed request refused before activation
    wr(4'h0, 32'h101);
    rdreg(4'h0, rd); check("R3 refused", rd, 32'h0);

    // R12 strobes with nothing enabled
    send_byte(8'hC3);
    rdreg(4'h0, rd); check("R12 idle strobes", rd, 32'h0);

    // R2 warm-up edge
    wr(4'hC, 32'h80);
    rdreg(4'hC, rd); check("R2 act readback", rd, 32'h80);
    repeat (WARM - 2) @(negedge clk);
    rdreg(4'h0, rd); check("R2 ready early", rd, ctl(0,0,0,0,0,0,0));
    rdreg(4'h0, rd); check("R2 ready on time", rd, ctl(0,0,0,0,1,0,0));

    // R9 clock range
    wr(4'h0, 32'h14);
    rdreg(4'h0, rd); check("R9 write while off", rd, ctl(0,0,5,0,1,0,0));
    wr(4'h0, 32'h3C);
    rdreg(4'h0, rd); check("R9 reserved code", rd, ctl(0,0,5,0,1,0,0));
    wr(4'h0, 32'h15);
    rdreg(4'h0, rd); check("R3 enable accepted", rd, ctl(1,0,5,0,1,0,0));
    wr(4'h0, 32'h0D);
    rdreg(4'h0, rd); check("R9 frozen while on", rd, ctl(1,0,5,0,1,0,0));

    // R4 R5 R6 R8 vector table
    for (int v = 0; v < NVEC; v++) begin
      wr(4'h0, 32'h15 | (32'(VECS[v][8]) << 6));
      send_byte(VECS[v][7:0]);
      rdreg(4'h0, rd); check("R4 valid set", rd, ctl(1,1,5,VECS[v][8],1,0,0));
      check("R8 irq level", 32'(irq), 32'(VECS[v][8]));
      rdreg(4'h4, rd); check("R5 byte read", rd, 32'(VECS[v][7:0]));
      rdreg(4'h4, rd); check("R6 empty read", rd, 32'h0);
      check("R8 irq clear", 32'(irq), 32'h0);
    end

    // R7 overflow discard
    send_byte(8'h11);
    send_byte(8'h22);
    rdreg(4'h4, rd); check("R7 held byte kept", rd, 32'h11);
    send_byte(8'h33);
    rdreg(4'h4, rd); check("R7 fresh group", rd, 32'h33);

    // R10 R11 seed mode
    send_byte(8'h5A);
    wr(4'h0, 32'h115);
    rdreg(4'h4, rd); check("R11 data hidden", rd, 32'h0);
    rdreg(4'h0, rd); check("R11 dv kept, sr low", rd, ctl(1,1,5,0,1,1,0));
    send_word(32'hC0FFEE42);
    check("R10 seed word", seed_word, 32'hC0FFEE42);
    rdreg(4'h0, rd); check("R10 seed done", rd, ctl(1,1,5,0,1,0,1));
    rdreg(4'h4, rd); check("R11 byte survives", rd, 32'h5A);

    // R12 strobes while disabled
    wr(4'h0, 32'h14);
    send_byte(8'hE7);
    rdreg(4'h0, rd); check("R12 disabled strobes", rd, ctl(0,0,5,0,1,0,1));

    // R2 ready drop, R3 refusal after drop
    wr(4'hC, 32'h0);
    rdreg(4'h0, rd); check("R2 ready same cycle", rd, ctl(0,0,5,0,1,0,1));
    rdreg(4'h0, rd); check("R2 ready dropped", rd, ctl(0,0,5,0,0,0,1));
    wr(4'h0, 32'h115);
    rdreg(4'h0, rd); check("R3 refused after drop", rd, ctl(0,0,5,0,0,0,1));

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule